// File: doc/BRIEF.md
# Single-Bit Register Operation Unit

This unit carries out four single-bit instructions against a private file of 64 eight-bit registers. Two of them modify state: one forces a chosen bit to 0 and one forces it to 1. Both keep the other seven bits of the register unchanged. The other two only read. One tests whether the chosen bit is 0 and the other whether it is 1. When the tested condition holds, the unit raises a skip request.

A fetch stage feeds the unit a decoded operation class, a register address, a bit index and an execute strobe. The unit never branches. Its skip request tells the next-stage instruction register to replace the already-prefetched instruction with a NOP. A test therefore costs one cycle, or two cycles when it skips. None of the operations touch any status flag.

The register file reads combinationally and writes on the clock edge. A modification committed at one edge is therefore seen by an instruction presented in the following cycle.

Top module: `bitop_unit`

## Requirements
- R1: A synchronous active-high reset clears every register to 0x00 and drives the skip request low.
- R2: Operation class 2'b00 (clear) with the strobe high writes 0 into bit `bit_i` of register `addr_i` and leaves the other bits and all other registers unchanged.
- R3: Operation class 2'b01 (set) with the strobe high writes 1 into bit `bit_i` of register `addr_i` and leaves the other bits and all other registers unchanged.
- R4: Operation class 2'b10 (skip-if-clear) requests a skip when the selected bit is 0, requests none when it is 1, and modifies no register.
- R5: Operation class 2'b11 (skip-if-set) requests a skip when the selected bit is 1, requests none when it is 0, and modifies no register.
- R6: The skip request is registered. It is high only in the cycle immediately after the clock edge that samples a test whose condition holds, so each skip is a one-cycle pulse per test. Clear and set never raise it.
- R7: A test presented in the cycle right after a clear or set of the same register sees the updated bit.
- R8: With the strobe low, no register changes and no skip is requested, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_i | input | 1 | Execute strobe; the instruction on the other inputs runs at this edge |
| op_i | input | 2 | Operation class: 00 clear, 01 set, 10 skip-if-clear, 11 skip-if-set |
| addr_i | input | 6 | Register address, 0 to 63 |
| bit_i | input | 3 | Bit index, 0 to 7 |
| skip_o | output | 1 | Skip request to the fetch stage; the prefetched instruction becomes a NOP |

## Verification
Each instruction is driven at a falling edge and sampled by the next rising edge. Its skip result is due in the cycle that follows, so the bench reads `skip_o` at the next falling edge before it applies the next instruction. A clear or set has its effect at that same rising edge. The bench observes it through a test issued in the very next cycle, which makes register contents visible at the ports one cycle after the write. The sweeps cover all 512 register/bit pairs after reset, after a computed fill pattern, and under back-to-back write-then-test pairs.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [1:0] {
    BOP_CLR = 2'b00,
    BOP_SET = 2'b01,
    BOP_TSC = 2'b10,
    BOP_TSS = 2'b11
  } bop_e;
endpackage

// File: rtl/bitop_mask.sv
module bitop_mask #(
  parameter int WIDTH = 8,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic [IDX_W-1:0] idx,
  output logic [WIDTH-1:0] mask
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_dec
    assign mask[g] = (idx == IDX_W'(g));
  end
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  bop_e             op,
  input  logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] mask,
  output logic [WIDTH-1:0] wr_data,
  output logic             is_write,
  output logic             test_hit
);
  logic bit_val;

  always_comb begin
    bit_val  = |(rd_data & mask);
    is_write = (op == BOP_CLR) || (op == BOP_SET);
    wr_data  = (op == BOP_SET) ? (rd_data | mask) : (rd_data & ~mask);
    unique case (op)
      BOP_TSC: test_hit = ~bit_val;
      BOP_TSS: test_hit = bit_val;
      default: test_hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/bitop_regfile.sv
module bitop_regfile #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  assign rdata = mem[addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  // R2: a committed write is what the entry holds afterwards
  assert_write_commit_R2: assert property (@(posedge clk) disable iff (rst)
    (we) |=> (mem[$past(addr)] == $past(wdata)));

  // R8: without a write the addressed entry keeps its value
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!we) |=> (mem[$past(addr)] == $past(rdata)));
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int REG_COUNT = 64,
  parameter int REG_W     = 8,
  localparam int ADDR_W   = $clog2(REG_COUNT),
  localparam int IDX_W    = $clog2(REG_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exec_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [IDX_W-1:0]  bit_i,
  output logic              skip_o
);
  bop_e             op;
  logic [REG_W-1:0] mask;
  logic [REG_W-1:0] rd_data;
  logic [REG_W-1:0] wr_data;
  logic             is_write;
  logic             test_hit;
  logic             skip_q;

  assign op = bop_e'(op_i);

  bitop_mask #(.WIDTH(REG_W)) u_mask (
    .idx  (bit_i),
    .mask (mask)
  );

  bitop_regfile #(.DEPTH(REG_COUNT), .WIDTH(REG_W)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (exec_i && is_write),
    .addr  (addr_i),
    .wdata (wr_data),
    .rdata (rd_data)
  );

  bitop_alu #(.WIDTH(REG_W)) u_alu (
    .op       (op),
    .rd_data  (rd_data),
    .mask     (mask),
    .wr_data  (wr_data),
    .is_write (is_write),
    .test_hit (test_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) skip_q <= 1'b0;
    else     skip_q <= exec_i && test_hit;
  end

  assign skip_o = skip_q;

  // R1: first cycle out of reset carries no skip
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !skip_o);

  // R6: a skip only ever follows an executed test
  assert_skip_source_R6: assert property (@(posedge clk) disable iff (rst)
    skip_o |-> $past(exec_i && op_i[1]));

  // R8: an idle cycle raises no skip
  assert_idle_noskip_R8: assert property (@(posedge clk) disable iff (rst)
    (!exec_i) |=> !skip_o);

  // R7: set then skip-if-set on the same bit skips
  assert_set_fwd_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(exec_i) && $past(op_i) == 2'b01 && exec_i && op_i == 2'b11 &&
     addr_i == $past(addr_i) && bit_i == $past(bit_i)) |=> skip_o);

  // R7: clear then skip-if-clear on the same bit skips
  assert_clr_fwd_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(exec_i) && $past(op_i) == 2'b00 && exec_i && op_i == 2'b10 &&
     addr_i == $past(addr_i) && bit_i == $past(bit_i)) |=> skip_o);
endmodule

// File: tb/test_bitop_unit.sv
module test_bitop_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       exec_i = 1'b0;
  logic [1:0] op_i = 2'b00;
  logic [5:0] addr_i = '0;
  logic [2:0] bit_i = '0;
  logic       skip_o;

  int checks = 0;
  int failures = 0;
  logic [7:0] model_q [64];

  always #5 clk = ~clk;

  bitop_unit i_bitop_unit (
    .clk(clk), .rst(rst), .exec_i(exec_i), .op_i(op_i),
    .addr_i(addr_i), .bit_i(bit_i), .skip_o(skip_o)
  );

  task automatic check(input logic got, input logic want, input string tag);
    checks++;
    if (got !== want) begin
      failures++;
      $display("FAIL %s skip_o actual=%b expected=%b", tag, got, want);
    end
  endtask

  // Called at a falling edge; leaves at the next falling edge after checking skip.
  task automatic step(input logic en, input logic [1:0] op, input int a, input int b,
                      input string tag);
    logic want;
    want = en && op[1] && ((op == 2'b11) ? model_q[a][b] : !model_q[a][b]);
    exec_i = en; op_i = op; addr_i = 6'(a); bit_i = 3'(b);
    @(negedge clk);
    check(skip_o, want, tag);
    if (en && op == 2'b00) model_q[a][b] = 1'b0;
    if (en && op == 2'b01) model_q[a][b] = 1'b1;
    exec_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int a = 0; a < 64; a++) model_q[a] = 8'h00;
    repeat (3) @(negedge clk);
    check(skip_o, 1'b0, "R1 reset");
    rst = 1'b0;
    // R1: every bit reads zero after reset
    for (int a = 0; a < 64; a++)
      for (int b = 0; b < 8; b++) begin
        step(1'b1, 2'b11, a, b, "R1 tss after reset");
        step(1'b1, 2'b10, a, b, "R1 tsc after reset");
      end
    // R2/R3/R6: fill with computed pattern; writes never skip
    for (int a = 0; a < 64; a++)
      for (int b = 0; b < 8; b++) begin
        logic [7:0] v;
        v = 8'((a * 29 + 7) ^ (a << 2));
        step(1'b1, {1'b0, v[b]}, a, b, v[b] ? "R3 set fill" : "R2 clear fill");
      end
    // R4/R5: read back every bit with both tests; R6 idle gap after each
    for (int a = 0; a < 64; a++)
      for (int b = 0; b < 8; b++) begin
        step(1'b1, 2'b10, a, b, "R4 tsc sweep");
        step(1'b0, 2'b11, a, b, "R6 single pulse");
        step(1'b1, 2'b11, a, b, "R5 tss sweep");
      end
    // R7: invert each bit and test it back-to-back
    for (int a = 0; a < 64; a++)
      for (int b = 0; b < 8; b++) begin
        logic cur;
        cur = model_q[a][b];
        step(1'b1, {1'b0, !cur}, a, b, cur ? "R2 invert clear" : "R3 invert set");
        step(1'b1, cur ? 2'b10 : 2'b11, a, b, "R7 back-to-back");
      end
    // R8: strobe low with write opcodes changes nothing
    for (int a = 0; a < 64; a += 7)
      for (int b = 0; b < 8; b++) begin
        step(1'b0, {1'b0, !model_q[a][b]}, a, b, "R8 idle write");
        step(1'b1, 2'b11, a, b, "R8 idle readback");
      end
    // R2/R3: neighbours untouched after the inversion pass
    for (int a = 0; a < 64; a++)
      for (int b = 0; b < 8; b++)
        step(1'b1, 2'b10, a, b, "R2 final tsc");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule